// File: doc/BRIEF.md
# PLL Clock Source Control Register

This block is an 8-bit control register that decides where the system clock comes from. It selects either the crystal input or the output of a PLL, and it holds the PLL multiplication ratio. Software writes the register in one cycle and reads it back at any time. The register itself keeps the writes safe. It enforces the rules that tie the enable, ratio and source fields together. It also keeps a settling counter that must run out before the PLL output may be chosen as the clock source.

The counter advances on a timer tick input. The number of ticks is a parameter, sized so that the wait is about 2 ms. The counter restarts on reset and whenever the ratio is changed. The block drives control outputs only: a PLL enable, the ratio code, the multiplier it stands for, the source select, and a 2-bit peripheral clock divider select. The analog PLL, the oscillator and the glitch-free clock switch sit outside this block.

Top module: `pll_clkctl_reg`

## Requirements
- R1: After reset the register reads 0x00. In that state `pll_en`, `sel_pll`, `pll_ratio` and `periph_sel` are all 0, and `pll_mult` is 1.
- R2: Readback layout: bits 7:6 are the peripheral select, bit 5 is the source select (1 = PLL), bits 3:2 are the ratio and bit 1 is the PLL enable. Bits 4 and 0 always read 0. `rd_data` shows the stored effective value, so any forced or ignored bits appear as they really are.
- R3: A write with bit 1 = 0 clears the enable. The same write also leaves bit 5 at 0, whatever value bit 5 carries in that write.
- R4: While the stored enable is 0, bit 5 of a write is ignored. This holds even if the same write sets the enable, so selecting the PLL takes two writes.
- R5: `pll_mult` gives the multiplier of the stored ratio: 00 gives 1 (the reset ratio), 01 gives 2, 10 gives 3 and 11 gives 4.
- R6: After reset, only the first write whose bits 3:2 differ from the stored ratio is accepted. Every later ratio write is ignored until the next reset.
- R7: The write that changes the ratio leaves bit 5 at 0 and restarts the settling counter.
- R8: A write of 1 to bit 5 takes effect only after `SETTLE_TICKS` tick pulses have been counted since reset or since the last ratio change. An earlier write of 1 leaves bit 5 unchanged.
- R9: Bits 7:6 are plain read/write bits and drive `periph_sel`.
- R10: With the enable stored as 1, a write of 0 to bit 5 clears the source select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write value |
| tick | input | 1 | Settling timer tick, one cycle wide |
| rd_data | output | 8 | Effective register value |
| pll_en | output | 1 | PLL operation enable |
| pll_ratio | output | 2 | Stored multiplication ratio code |
| pll_mult | output | 3 | Multiplier of the stored ratio |
| sel_pll | output | 1 | 1 = PLL output is the system clock |
| periph_sel | output | 2 | Peripheral clock divider select |

## Verification
The bench builds the block with `SETTLE_TICKS` set to 4 instead of the roughly 2 ms default. This lets the settling counter expire within a few writes. Early and on-time writes of 1 to the source select can then both be tried: once after reset, again after a ratio change, and again after a second reset. A mid-run reset also unlocks the ratio field, so the once-only rule is checked twice in one run.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  // Field positions; software and the downstream clock logic rely on them.
  localparam int unsigned BIT_EN     = 1;
  localparam int unsigned BIT_RLO    = 2;
  localparam int unsigned BIT_RHI    = 3;
  localparam int unsigned BIT_SEL    = 5;
  localparam int unsigned BIT_PLO    = 6;
  localparam int unsigned BIT_PHI    = 7;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned RATIO_W    = 2;
  localparam int unsigned MULT_W     = 3;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Multiplier of a ratio code: 00 is the reset ratio (x1).
  function automatic logic [MULT_W-1:0] ratio_to_mult(input ratio_t code);
    logic [MULT_W-1:0] m;
    case (code)
      2'b01:   m = 3'd2;
      2'b10:   m = 3'd3;
      2'b11:   m = 3'd4;
      default: m = 3'd1;
    endcase
    return m;
  endfunction

  // Assemble the readback image from the stored fields.
  function automatic logic [REG_W-1:0] pack_image(input logic [1:0] periph,
                                                  input logic       sel,
                                                  input ratio_t     ratio,
                                                  input logic       en);
    logic [REG_W-1:0] img;
    img = '0;
    img[BIT_PHI:BIT_PLO] = periph;
    img[BIT_SEL]         = sel;
    img[BIT_RHI:BIT_RLO] = ratio;
    img[BIT_EN]          = en;
    return img;
  endfunction

endpackage

// File: rtl/clkctl_settle_timer.sv
module clkctl_settle_timer #(
  parameter int unsigned TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  output logic done
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      remain_q <= LOAD;
    end else if (tick && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign done = (remain_q == '0);
endmodule

// File: rtl/clkctl_ratio_guard.sv
module clkctl_ratio_guard
  import clkctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  ratio_t wr_ratio,
  output ratio_t ratio_q,
  output logic   locked_q,
  output logic   change
);
  // A change is a write with a differing code while the field is still open.
  assign change = wr_en && !locked_q && (wr_ratio != ratio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q  <= '0;
      locked_q <= 1'b0;
    end else if (change) begin
      ratio_q  <= wr_ratio;
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/clkctl_sel_gate.sv
module clkctl_sel_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sel,
  input  logic wr_enable,
  input  logic en_q,
  input  logic ratio_change,
  input  logic settle_done,
  output logic sel_q,
  output logic sel_held
);
  logic sel_d;

  // sel_held marks a write of 1 that the interlocks refuse.
  assign sel_held = wr_en && wr_sel && wr_enable && en_q && !ratio_change && !settle_done;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) begin
      if (!wr_enable || !en_q || ratio_change) begin
        sel_d = 1'b0;
      end else if (!wr_sel) begin
        sel_d = 1'b0;
      end else if (settle_done) begin
        sel_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/pll_clkctl_reg.sv
module pll_clkctl_reg
  import clkctl_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tick,
  output logic [7:0] rd_data,
  output logic       pll_en,
  output logic [1:0] pll_ratio,
  output logic [2:0] pll_mult,
  output logic       sel_pll,
  output logic [1:0] periph_sel
);
  logic       en_q;
  logic [1:0] periph_q;
  ratio_t     ratio_q;
  logic       ratio_locked;
  logic       ratio_change;
  logic       settle_done;
  logic       sel_q;
  logic       sel_held;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[4], wr_data[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      periph_q <= '0;
    end else if (wr_en) begin
      en_q     <= wr_data[BIT_EN];
      periph_q <= wr_data[BIT_PHI:BIT_PLO];
    end
  end

  clkctl_ratio_guard u_ratio (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ratio (wr_data[BIT_RHI:BIT_RLO]),
    .ratio_q  (ratio_q),
    .locked_q (ratio_locked),
    .change   (ratio_change)
  );

  clkctl_settle_timer #(.TICKS(SETTLE_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (ratio_change),
    .done    (settle_done)
  );

  clkctl_sel_gate u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_data[BIT_SEL]),
    .wr_enable    (wr_data[BIT_EN]),
    .en_q         (en_q),
    .ratio_change (ratio_change),
    .settle_done  (settle_done),
    .sel_q        (sel_q),
    .sel_held     (sel_held)
  );

  assign rd_data    = pack_image(periph_q, sel_q, ratio_q, en_q);
  assign pll_en     = en_q;
  assign pll_ratio  = ratio_q;
  assign pll_mult   = ratio_to_mult(ratio_q);
  assign sel_pll    = sel_q;
  assign periph_sel = periph_q;
endmodule

// File: rtl/clkctl_checker.sv
module clkctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       pll_en,
  input logic       sel_pll,
  input logic [1:0] pll_ratio,
  input logic [1:0] periph_sel,
  input logic       settle_done,
  input logic       ratio_locked,
  input logic       ratio_change,
  input logic       sel_held
);
  assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] == 1'b0) && (rd_data[0] == 1'b0));

  assert_disable_clears_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[1]) |=> (!pll_en && !sel_pll));

  assert_sel_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en |-> !sel_pll));

  assert_ratio_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_locked |=> $stable(pll_ratio));

  assert_ratio_change_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_change |=> (!sel_pll && !settle_done));

  assert_sel_after_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_pll) |-> $past(settle_done));

  assert_held_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_held |=> $stable(sel_pll));

  assert_periph_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (periph_sel == $past(wr_data[7:6])));
endmodule

bind pll_clkctl_reg clkctl_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .pll_en       (pll_en),
  .sel_pll      (sel_pll),
  .pll_ratio    (pll_ratio),
  .periph_sel   (periph_sel),
  .settle_done  (settle_done),
  .ratio_locked (ratio_locked),
  .ratio_change (ratio_change),
  .sel_held     (sel_held)
);

// File: tb/sim_pll_clkctl_reg.sv
module sim_pll_clkctl_reg;
  localparam int unsigned TICKS = 4;
  localparam int NVEC = 16;
  // {tick pulses before the write, write value, expected readback}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    24'h00_20_00, // R4 sel while disabled
    24'h00_22_02, // R4 enable and sel in one write
    24'h00_22_02, // R8 counter not expired
    24'h03_22_02, // R8 one tick short
    24'h01_22_22, // R8 expired, sel taken
    24'h00_E2_E2, // R9 peripheral bits
    24'h00_40_40, // R3 disable clears sel
    24'h00_62_42, // R4 re-enable, sel ignored
    24'h00_62_62, // R10/R8 sel accepted, counter still expired
    24'h00_6A_4A, // R7 ratio change clears sel
    24'h00_6A_4A, // R7 counter restarted
    24'h04_6A_6A, // R8 counter expired again
    24'h00_6E_6A, // R6 second ratio write ignored
    24'h00_42_4A, // R6 R10 ratio kept, sel cleared
    24'h00_FF_EA, // R2 spare bits read 0
    24'h00_00_08  // R3 all cleared but locked ratio
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] rd_data;
  logic       pll_en;
  logic [1:0] pll_ratio;
  logic [2:0] pll_mult;
  logic       sel_pll;
  logic [1:0] periph_sel;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pll_clkctl_reg #(.SETTLE_TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .rd_data(rd_data), .pll_en(pll_en), .pll_ratio(pll_ratio), .pll_mult(pll_mult),
    .sel_pll(sel_pll), .periph_sel(periph_sel)
  );

  function automatic logic [2:0] mult_of(input logic [7:0] img);
    return {1'b0, img[3:2]} + 3'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [7:0] exp);
    check(req, rd_data, exp);
    check(req, {pll_en, sel_pll, pll_ratio, periph_sel},
          {exp[1], exp[5], exp[3:2], exp[7:6]});
    check({req, " R5"}, pll_mult, mult_of(exp));
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check_all("R1 reset", 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      pulse_ticks(int'(VEC[v][23:16]));
      write(VEC[v][15:8]);
      check_all($sformatf("vec%0d", v), VEC[v][7:0]);
    end

    // Reset mid-run: register clears, ratio unlocks, counter restarts.
    do_reset();
    check_all("R1 second reset", 8'h00);
    write(8'h02);
    write(8'h22);
    check_all("R8 counter restarted by reset", 8'h02);
    write(8'h06);
    check_all("R6 ratio open again after reset", 8'h06);
    check("R5 x2", pll_mult, 3'd2);
    write(8'h0E);
    check_all("R6 locked after one change", 8'h06);
    pulse_ticks(TICKS);
    write(8'h26);
    check_all("R8 sel after settle", 8'h26);
    write(8'h06);
    check_all("R10 sel cleared", 8'h06);
    write(8'h24);
    check_all("R3 disable with sel set", 8'h04);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule